// File: doc/BRIEF.md
# Multi-Protocol Parallel Host Register Port

This block is the slave side of a parallel microprocessor bus. It gives an external host read and write access to an internal bank of 128 registers, each 8 bits wide. A static two-bit mode input chooses one of three bus styles:

- **Multiplexed.** A single 8-bit bus carries the address first and the data after it. An address-latch strobe marks the address phase.
- **Split-strobe.** There are separate active-low read and write strobes.
- **Direction-line.** The chip select frames the access, and one read/write line sets its direction.

An active-low chip select qualifies every access. Every bus input is resynchronized into the system clock domain before it is used.

The host sees an 8-bit data input, an 8-bit data output and an output enable. The pad logic combines these three into the shared bidirectional bus. A write is committed once, when the synchronized write strobe ends. A read loads its data when the synchronized read starts. That data then stays frozen for as long as the output enable is high.

Top module: `hostBusPort`

## Requirements
- R1: After reset every register reads as zero and `dataOe` is low.
- R2: In split-strobe mode (`busMode` = 2'b01), with `csN` low, a low pulse on `wrN` writes `dataIn` to the register at `addrIn`. The write is committed once, when the strobe ends.
- R3: In split-strobe mode, while `csN` and `rdN` are both low, `dataOe` is high and `dataOut` shows the register at `addrIn`.
- R4: In multiplexed mode (`busMode` = 2'b00), the register address is `dataIn[6:0]` as sampled when `aleIn` falls. The `addrIn` pins are ignored, and `wrN`/`rdN` act as in split-strobe mode.
- R5: In direction-line mode (`busMode` = 2'b10), an access is active while `csN` is low. It is a write when `wrN` is low and a read when `wrN` is high. The level on `rdN` has no effect.
- R6: While `csN` is high, no register is written and `dataOe` stays low.
- R7: `dataOut` is stable for every cycle that `dataOe` is high. `dataOe` falls on the third rising clock edge after the read condition is removed at the pins.
- R8: `dataOe` rises on the third rising clock edge after a read condition appears at the pins.
- R9: Mode code 2'b11 performs no access. No register changes and `dataOe` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busMode | input | 2 | Bus style: 00 multiplexed, 01 split-strobe, 10 direction-line, 11 off |
| csN | input | 1 | Active-low chip select |
| aleIn | input | 1 | Address-latch strobe (multiplexed mode) |
| wrN | input | 1 | Write strobe, or read/write direction in direction-line mode |
| rdN | input | 1 | Active-low read strobe (unused in direction-line mode) |
| addrIn | input | 7 | Register address for the non-multiplexed modes |
| dataIn | input | 8 | Bus input: data, or address during the ALE phase |
| dataOut | output | 8 | Read data toward the bus pads |
| dataOe | output | 1 | Pad output enable for `dataOut` |

## Verification
The bench sweeps all 128 addresses in each of the three bus styles, using a distinct arithmetic data pattern per mode.

- **Address source in multiplexed mode.** `addrIn` carries the inverse of the real address during these accesses. A design that took the address from the wrong source would read back the wrong words.
- **Ignored `rdN` in direction-line mode.** `rdN` is toggled during these accesses. A design that decoded it would lose or corrupt writes.
- **Accesses that must do nothing.** Writes with chip select high and writes in the off mode must leave the stored value intact. A leaky qualifier would overwrite it.
- **Output-enable timing.** `dataOe` is sampled cycle by cycle on its rise and on its fall. A missing or extra synchronizer stage would shift the edge, and a read register that tracked the bus would change `dataOut` while it is driven.

// File: rtl/hostBusPkg.sv
package hostBusPkg;

  typedef enum logic [1:0] {
    MODE_MUX = 2'b00,
    MODE_SEP = 2'b01,
    MODE_DIR = 2'b10,
    MODE_OFF = 2'b11
  } busModeE;

  // Strobes from control to datapath, all aligned to the synchronized bus.
  typedef struct packed {
    logic latchAddr;   // address-latch strobe just fell
    logic useMuxAddr;  // take address from the latched bus value
    logic captureWr;   // write is active this cycle
    logic commitWr;    // write just ended: store captured word
    logic startRd;     // read just began: load the read holding register
    logic readAct;     // read is active
  } ctrlStrobeS;

endpackage

// File: rtl/hostBusSync.sv
module hostBusSync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= RESET_VAL;
    end else begin
      stage[0] <= d;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];

endmodule

// File: rtl/hostRegBank.sv
module hostRegBank #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              we,
  input  logic [ADDR_W-1:0] wAddr,
  input  logic [DATA_W-1:0] wData,
  input  logic [ADDR_W-1:0] rAddr,
  output logic [DATA_W-1:0] rData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[wAddr] <= wData;
    end
  end

  assign rData = mem[rAddr];

endmodule

// File: rtl/hostBusCtrl.sv
module hostBusCtrl
  import hostBusPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] busMode,
  input  logic       csN,
  input  logic       aleIn,
  input  logic       wrN,
  input  logic       rdN,
  output ctrlStrobeS strobes
);

  localparam logic [3:0] IDLE_LEVELS = 4'b1011; // csN, ale, wrN, rdN

  logic [3:0] pinVec, syncVec;
  logic csS, aleS, wrS, rdS;
  logic aleQ, wrActQ, rdActQ;
  logic wrAct, rdAct, isMux;

  assign pinVec = {csN, aleIn, wrN, rdN};

  hostBusSync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RESET_VAL(IDLE_LEVELS)) u_pinSync (
    .clk(clk), .rstN(rstN), .d(pinVec), .q(syncVec)
  );

  assign {csS, aleS, wrS, rdS} = syncVec;

  // Protocol decode: which access is in progress in the synchronized domain.
  always_comb begin
    wrAct = 1'b0;
    rdAct = 1'b0;
    isMux = 1'b0;
    unique case (busModeE'(busMode))
      MODE_MUX: begin
        isMux = 1'b1;
        wrAct = !csS && !wrS;
        rdAct = !csS && !rdS && wrS;
      end
      MODE_SEP: begin
        wrAct = !csS && !wrS;
        rdAct = !csS && !rdS && wrS;
      end
      MODE_DIR: begin
        wrAct = !csS && !wrS;
        rdAct = !csS && wrS;
      end
      default: begin
        wrAct = 1'b0;
        rdAct = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aleQ   <= 1'b0;
      wrActQ <= 1'b0;
      rdActQ <= 1'b0;
    end else begin
      aleQ   <= aleS;
      wrActQ <= wrAct;
      rdActQ <= rdAct;
    end
  end

  always_comb begin
    strobes.latchAddr  = isMux && aleQ && !aleS;
    strobes.useMuxAddr = isMux;
    strobes.captureWr  = wrAct;
    strobes.commitWr   = wrActQ && !wrAct;
    strobes.startRd    = rdAct && !rdActQ;
    strobes.readAct    = rdAct;
  end

endmodule

// File: rtl/hostBusDatapath.sv
module hostBusDatapath
  import hostBusPkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  input  ctrlStrobeS        strobes,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);

  logic [ADDR_W-1:0] addrS, muxAddr, accessAddr, wrAddrHold;
  logic [DATA_W-1:0] dataS, wrDataHold, readHold, bankData;

  // Address and data follow the same pipeline depth as the strobes.
  hostBusSync #(.WIDTH(ADDR_W), .STAGES(SYNC_STAGES)) u_addrSync (
    .clk(clk), .rstN(rstN), .d(addrIn), .q(addrS)
  );
  hostBusSync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES)) u_dataSync (
    .clk(clk), .rstN(rstN), .d(dataIn), .q(dataS)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) muxAddr <= '0;
    else if (strobes.latchAddr) muxAddr <= dataS[ADDR_W-1:0];
  end

  assign accessAddr = strobes.useMuxAddr ? muxAddr : addrS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrAddrHold <= '0;
      wrDataHold <= '0;
    end else if (strobes.captureWr) begin
      wrAddrHold <= accessAddr;
      wrDataHold <= dataS;
    end
  end

  hostRegBank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rstN(rstN),
    .we(strobes.commitWr), .wAddr(wrAddrHold), .wData(wrDataHold),
    .rAddr(accessAddr), .rData(bankData)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readHold <= '0;
      dataOe   <= 1'b0;
    end else begin
      if (strobes.startRd) readHold <= bankData;
      dataOe <= strobes.readAct;
    end
  end

  assign dataOut = readHold;

endmodule

// File: rtl/hostBusPort.sv
module hostBusPort
  import hostBusPkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busMode,
  input  logic              csN,
  input  logic              aleIn,
  input  logic              wrN,
  input  logic              rdN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);

  ctrlStrobeS strobes;
  logic wrCommit;

  hostBusCtrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .busMode(busMode),
    .csN(csN), .aleIn(aleIn), .wrN(wrN), .rdN(rdN),
    .strobes(strobes)
  );

  hostBusDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .dataIn(dataIn),
    .strobes(strobes), .dataOut(dataOut), .dataOe(dataOe)
  );

  assign wrCommit = strobes.commitWr;

endmodule

// File: rtl/hostBusChecker.sv
module hostBusChecker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        busMode,
  input logic              csN,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataOe,
  input logic              wrCommit
);

  // R1: output enable is low as reset is released
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !dataOe);

  // R2: a write commits in a single cycle only
  assert_single_commit_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrCommit |=> !wrCommit);

  // R6: chip select held high blocks writes and the output enable
  assert_cs_guard_R6: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3)) |-> (!wrCommit && !dataOe));

  // R7: read data frozen while driven
  assert_read_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe && $past(dataOe)) |-> $stable(dataOut));

  // R8: enable only rises for an access that had chip select low three edges back
  assert_oe_latency_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataOe) |-> !$past(csN, 3));

  // R9: off mode performs nothing
  assert_off_mode_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busMode == 2'b11 && $past(busMode) == 2'b11 && $past(busMode, 2) == 2'b11 &&
     $past(busMode, 3) == 2'b11) |-> (!dataOe && !wrCommit));

endmodule

bind hostBusPort hostBusChecker #(.DATA_W(DATA_W)) u_hostBusChecker (
  .clk(clk), .rstN(rstN), .busMode(busMode), .csN(csN),
  .dataOut(dataOut), .dataOe(dataOe), .wrCommit(wrCommit)
);

// File: tb/tb_hostBusPort.sv
module tb_hostBusPort;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] busMode = 2'b01;
  logic csN = 1'b1, aleIn = 1'b0, wrN = 1'b1, rdN = 1'b1;
  logic [6:0] addrIn = '0;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut;
  logic dataOe;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hostBusPort dut (
    .clk(clk), .rstN(rstN), .busMode(busMode), .csN(csN), .aleIn(aleIn),
    .wrN(wrN), .rdN(rdN), .addrIn(addrIn), .dataIn(dataIn),
    .dataOut(dataOut), .dataOe(dataOe)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] patSep(input int a); return 8'((a * 37 + 11) & 255); endfunction
  function automatic logic [7:0] patMux(input int a); return 8'(a) ^ 8'h5A; endfunction
  function automatic logic [7:0] patDir(input int a); return 8'((a * 13 + 7) & 255); endfunction

  task automatic doWrite(input logic [1:0] m, input int a, input logic [7:0] d,
                         input logic csLvl, input logic rdTie);
    if (m == 2'b00) begin
      csN = csLvl; aleIn = 1'b1; dataIn = 8'(a); addrIn = ~7'(a);
      cyc(3); aleIn = 1'b0; cyc(4);
      dataIn = d; wrN = 1'b0; cyc(4); wrN = 1'b1; cyc(4); csN = 1'b1; cyc(3);
    end else if (m == 2'b10) begin
      addrIn = 7'(a); dataIn = d; rdN = rdTie; wrN = 1'b0; cyc(1);
      csN = csLvl; cyc(4); csN = 1'b1; cyc(4); wrN = 1'b1; cyc(3);
    end else begin
      addrIn = 7'(a); dataIn = d; csN = csLvl; cyc(1);
      wrN = 1'b0; cyc(4); wrN = 1'b1; cyc(4); csN = 1'b1; cyc(3);
    end
  endtask

  task automatic doRead(input logic [1:0] m, input int a, input logic csLvl,
                        input logic rdTie, output logic [7:0] d, output logic oe);
    if (m == 2'b00) begin
      csN = csLvl; aleIn = 1'b1; dataIn = 8'(a); addrIn = ~7'(a);
      cyc(3); aleIn = 1'b0; cyc(4);
      dataIn = 8'hC3; rdN = 1'b0; cyc(5); oe = dataOe; d = dataOut;
      rdN = 1'b1; cyc(4); csN = 1'b1; cyc(3);
    end else if (m == 2'b10) begin
      addrIn = 7'(a); rdN = rdTie; wrN = 1'b1; csN = csLvl; cyc(5);
      oe = dataOe; d = dataOut; csN = 1'b1; cyc(4);
    end else begin
      addrIn = 7'(a); csN = csLvl; cyc(1);
      rdN = 1'b0; cyc(5); oe = dataOe; d = dataOut;
      rdN = 1'b1; cyc(4); csN = 1'b1; cyc(3);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic oe;
    int errs;
    cyc(5);
    check("R1 oe in reset", dataOe, 0);
    rstN = 1'b1;
    cyc(3);
    check("R1 oe after reset", dataOe, 0);

    // R1: all words zero after reset
    busMode = 2'b01;
    errs = 0;
    for (int a = 0; a < 128; a++) begin
      doRead(2'b01, a, 1'b0, 1'b1, rd, oe);
      if (rd !== 8'h00 || oe !== 1'b1) errs++;
    end
    check("R1 zero sweep mismatches", errs, 0);

    // R2 / R3: split-strobe sweep
    for (int a = 0; a < 128; a++) doWrite(2'b01, a, patSep(a), 1'b0, 1'b1);
    for (int a = 0; a < 128; a++) begin
      doRead(2'b01, a, 1'b0, 1'b1, rd, oe);
      if (a < 4 || a > 124) begin
        check("R2 split write/read data", rd, patSep(a));
        check("R3 split read oe", oe, 1);
      end else if (rd !== patSep(a) || oe !== 1'b1) begin
        check("R3 split sweep word", rd, patSep(a));
      end
    end

    // R8 / R7: exact enable timing and hold while driven
    addrIn = 7'd9; csN = 1'b0; cyc(1);
    rdN = 1'b0; cyc(2);
    check("R8 oe after two edges", dataOe, 0);
    cyc(1);
    check("R8 oe after third edge", dataOe, 1);
    check("R7 read word", dataOut, patSep(9));
    addrIn = 7'd50; cyc(3);
    check("R7 data held after address change", dataOut, patSep(9));
    rdN = 1'b1; cyc(2);
    check("R7 oe still high two edges after release", dataOe, 1);
    cyc(1);
    check("R7 oe low on third edge after release", dataOe, 0);
    csN = 1'b1; cyc(3);

    // R4: multiplexed sweep, addrIn carries inverted garbage
    busMode = 2'b00; cyc(3);
    for (int a = 0; a < 128; a++) doWrite(2'b00, a, patMux(a), 1'b0, 1'b1);
    errs = 0;
    for (int a = 0; a < 128; a++) begin
      doRead(2'b00, a, 1'b0, 1'b1, rd, oe);
      if (rd !== patMux(a) || oe !== 1'b1) errs++;
      if (a == 3) check("R4 mux word 3", rd, patMux(3));
    end
    check("R4 mux sweep mismatches", errs, 0);

    // R5: direction-line sweep, rdN toggled and ignored
    busMode = 2'b10; cyc(3);
    for (int a = 0; a < 128; a++) doWrite(2'b10, a, patDir(a), 1'b0, 1'(a & 1));
    errs = 0;
    for (int a = 0; a < 128; a++) begin
      doRead(2'b10, a, 1'b0, 1'((a >> 1) & 1), rd, oe);
      if (rd !== patDir(a) || oe !== 1'b1) errs++;
      if (a == 77) check("R5 direction word 77", rd, patDir(77));
    end
    check("R5 direction sweep mismatches", errs, 0);

    // R6: chip select high blocks write and read
    busMode = 2'b01; cyc(3);
    doWrite(2'b01, 10, 8'hEE, 1'b1, 1'b1);
    doRead(2'b01, 10, 1'b1, 1'b1, rd, oe);
    check("R6 oe with cs high", oe, 0);
    doRead(2'b01, 10, 1'b0, 1'b1, rd, oe);
    check("R6 word unchanged", rd, patDir(10));

    // R9: off mode
    busMode = 2'b11; cyc(3);
    doWrite(2'b11, 20, 8'h99, 1'b0, 1'b1);
    doRead(2'b11, 20, 1'b0, 1'b1, rd, oe);
    check("R9 oe in off mode", oe, 0);
    busMode = 2'b01; cyc(3);
    doRead(2'b01, 20, 1'b0, 1'b1, rd, oe);
    check("R9 word unchanged", rd, patDir(20));

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule